// File: doc/BRIEF.md
# UART Receive Character Buffer with Per-Character Error Tags

This block sits between the receive shift register of a UART channel and the host-side holding-register port. Each character the shift register assembles arrives here along with its three error flags. Both are stored together as a single entry in a 64-entry first-in first-out buffer, and the host reads them back in arrival order. Outputs are registered: the character and its flags appear the cycle after the host issues a read strobe.

A FIFO control register, which lives outside this block, drives three things:

- an enable level that turns buffering on or off;
- a one-cycle clear pulse;
- a 2-bit receive trigger select.

With buffering off, the block keeps a single character in slot zero, and each new arrival replaces it. A registered trigger flag tells interrupt or DMA logic that the stored count has reached the selected threshold. A sticky overrun flag records any character that was lost or overwritten before the host read it. A host status-read strobe clears the overrun flag.

Top module: `uart_rx_fifo`

## Requirements
- R1: After synchronous reset, `rx_ready`, `trig_hit` and `overrun` are 0, and `rd_data` and `rd_err` are 0.
- R2: Characters are returned in arrival order. Each character comes back with the exact error bits written alongside it. `rd_data`/`rd_err` are updated on the clock edge that samples `rd_req`, when the buffer holds at least one entry.
- R3: With buffering enabled, 64 characters are held. A write while 64 are stored, and no read is accepted in the same cycle, is discarded; the stored contents are unchanged.
- R4: `overrun` goes to 1 on the edge at which a character is discarded or overwritten unread. It stays at 1 until a cycle in which `stat_rd` is 1 and no new loss occurs; it reads 0 after that edge.
- R5: With `fifo_en` = 0, only one character is stored. A new write replaces it, and `overrun` is set if it had not been read. A read returns the newest character and leaves the buffer empty.
- R6: `trig_hit` is 1 exactly when the stored count is at least the selected threshold. The trigger select codes map as 00 = 8, 01 = 16, 10 = 56 and 11 = 60. The flag is updated on the same edge as the count.
- R7: A cycle with `rx_clr` = 1 empties the buffer, and a write in that same cycle is ignored. `rx_ready` and `trig_hit` read 0 after that edge. The clear takes effect in one cycle, so the pulse needs no acknowledgement.
- R8: A read strobe while the buffer is empty leaves `rd_data`/`rd_err` unchanged and moves no pointer. A later write and read returns the new character.
- R9: A change of `fifo_en` empties the buffer on the next edge.
- R10: When the buffer is full and a read and a write occur in the same cycle, both are accepted. The read returns the oldest entry, `overrun` stays 0, and the new character is kept at the tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Buffering enable (1 = 64-entry FIFO, 0 = single slot) |
| rx_clr | input | 1 | One-cycle clear request |
| trig_sel | input | 2 | Receive trigger select (00=8, 01=16, 10=56, 11=60) |
| wr_valid | input | 1 | Assembled character valid from the shift register |
| wr_data | input | 8 | Assembled character |
| wr_err | input | 3 | Error flags of that character |
| rd_req | input | 1 | Host read strobe of the holding register |
| stat_rd | input | 1 | Host status read strobe, clears overrun |
| rd_data | output | 8 | Character read out |
| rd_err | output | 3 | Error flags of the character read out |
| rx_ready | output | 1 | At least one character stored |
| trig_hit | output | 1 | Stored count at or above threshold |
| overrun | output | 1 | Sticky character-lost flag |

## Verification
The hardest state to reach from the ports is a completely full buffer that receives a host read and a new character in the same cycle. In that cycle the write pointer equals the read pointer, and the storage must return the old entry while accepting the new one without flagging a loss. The stimulus first writes 64 characters, provokes one discard, and clears the flag. It then drives `wr_valid` and `rd_req` together and drains all 64 entries to confirm the exact sequence. A second hard case is single-slot mode: reaching it requires a flush through an enable change first, and the overwrite is then observed only through `overrun` and the value of the next read.

// File: rtl/uart_rx_fifo_pkg.sv
package uart_rx_fifo_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned ERR_W  = 3;

  typedef struct packed {
    logic [ERR_W-1:0]  err;
    logic [CHAR_W-1:0] chr;
  } rx_entry_t;
endpackage

// File: rtl/rxf_mem.sv
module rxf_mem #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 11,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // simple dual port, read-first, registered output
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          clr,
  input  logic          wr_valid,
  input  logic          rd_req,
  input  logic          stat_rd,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic          overrun
);
  logic [AW-1:0] wptr, rptr;
  logic          en_q;
  logic          flush, full, rd_ok, wr_ok, lost_char;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    flush     = clr | (fifo_en != en_q);
    full      = (cnt_q == CW'(DEPTH));
    rd_ok     = rd_req & (cnt_q != '0) & ~flush;
    wr_ok     = wr_valid & ~flush & (~fifo_en | ~full | rd_ok);
    lost_char = wr_valid & ~flush & ~rd_ok & (fifo_en ? full : (cnt_q != '0));
    if (flush)
      cnt_nxt = '0;
    else if (!fifo_en)
      cnt_nxt = wr_ok ? CW'(1) : (rd_ok ? '0 : cnt_q);
    else
      cnt_nxt = cnt_q + {{(CW-1){1'b0}}, wr_ok} - {{(CW-1){1'b0}}, rd_ok};
  end

  assign mem_we    = wr_ok;
  assign mem_re    = rd_ok;
  assign mem_waddr = fifo_en ? wptr : '0;
  assign mem_raddr = fifo_en ? rptr : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt_q   <= '0;
      en_q    <= fifo_en;
      overrun <= 1'b0;
    end else begin
      en_q  <= fifo_en;
      cnt_q <= cnt_nxt;
      if (flush || !fifo_en) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (wr_ok) wptr <= bump(wptr);
        if (rd_ok) rptr <= bump(rptr);
      end
      if (lost_char)    overrun <= 1'b1;
      else if (stat_rd) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/rxf_trig.sv
module rxf_trig #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned TH0   = 8,
  parameter int unsigned TH1   = 16,
  parameter int unsigned TH2   = 56,
  parameter int unsigned TH3   = 60,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    sel,
  input  logic [CW-1:0] cnt_nxt,
  output logic          trig_hit,
  output logic          ready
);
  logic [CW-1:0] thr;

  always_comb begin
    case (sel)
      2'b00:   thr = CW'(TH0);
      2'b01:   thr = CW'(TH1);
      2'b10:   thr = CW'(TH2);
      default: thr = CW'(TH3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_hit <= 1'b0;
      ready    <= 1'b0;
    end else begin
      trig_hit <= (cnt_nxt >= thr);
      ready    <= (cnt_nxt != '0);
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned TH0   = 8,
  parameter int unsigned TH1   = 16,
  parameter int unsigned TH2   = 56,
  parameter int unsigned TH3   = 60,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_en,
  input  logic              rx_clr,
  input  logic [1:0]        trig_sel,
  input  logic              wr_valid,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic [ERR_W-1:0]  wr_err,
  input  logic              rd_req,
  input  logic              stat_rd,
  output logic [CHAR_W-1:0] rd_data,
  output logic [ERR_W-1:0]  rd_err,
  output logic              rx_ready,
  output logic              trig_hit,
  output logic              overrun
);
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [CW-1:0] cnt_q, cnt_nxt;
  rx_entry_t     wentry, rentry;

  assign wentry.chr = wr_data;
  assign wentry.err = wr_err;
  assign rd_data    = rentry.chr;
  assign rd_err     = rentry.err;

  rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .clr(rx_clr),
    .wr_valid(wr_valid), .rd_req(rd_req), .stat_rd(stat_rd),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_re(mem_re),
    .mem_raddr(mem_raddr), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt),
    .overrun(overrun)
  );

  rxf_mem #(.DEPTH(DEPTH), .W($bits(rx_entry_t))) u_mem (
    .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(wentry),
    .re(mem_re), .raddr(mem_raddr), .rdata(rentry)
  );

  rxf_trig #(.DEPTH(DEPTH), .TH0(TH0), .TH1(TH1), .TH2(TH2), .TH3(TH3)) u_trig (
    .clk(clk), .rst(rst), .sel(trig_sel), .cnt_nxt(cnt_nxt),
    .trig_hit(trig_hit), .ready(rx_ready)
  );
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = 7,
  parameter int unsigned DW    = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          fifo_en,
  input logic          rx_clr,
  input logic          wr_valid,
  input logic          rd_req,
  input logic          stat_rd,
  input logic [DW-1:0] rd_data,
  input logic          rx_ready,
  input logic          trig_hit,
  input logic          overrun,
  input logic [CW-1:0] cnt_q
);
  // R3
  cap_limit_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));

  // R4
  overrun_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(wr_valid));

  // R4
  overrun_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (overrun && !stat_rd) |=> overrun);

  // R8
  empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rx_ready) |=> $stable(rd_data));

  // R7
  clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
    rx_clr |=> (!rx_ready && !trig_hit));

  // R5
  single_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (!fifo_en && $past(!fifo_en)) |-> (cnt_q <= CW'(1)));
endmodule

bind uart_rx_fifo rxf_chk #(.DEPTH(DEPTH), .CW(CW), .DW(uart_rx_fifo_pkg::CHAR_W)) u_chk (
  .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_clr(rx_clr),
  .wr_valid(wr_valid), .rd_req(rd_req), .stat_rd(stat_rd),
  .rd_data(rd_data), .rx_ready(rx_ready), .trig_hit(trig_hit),
  .overrun(overrun), .cnt_q(cnt_q)
);

// File: tb/sim_uart_rx_fifo.sv
`timescale 1ns/1ps
module sim_uart_rx_fifo;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_en = 1'b1, rx_clr = 1'b0, wr_valid = 1'b0, rd_req = 1'b0, stat_rd = 1'b0;
  logic [1:0] trig_sel = 2'b00;
  logic [7:0] wr_data = '0;
  logic [2:0] wr_err = '0;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic       rx_ready, trig_hit, overrun;
  int         total = 0, fails = 0;

  always #5 clk = ~clk;

  uart_rx_fifo u0 (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_clr(rx_clr), .trig_sel(trig_sel),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_err(wr_err), .rd_req(rd_req),
    .stat_rd(stat_rd), .rd_data(rd_data), .rd_err(rd_err), .rx_ready(rx_ready),
    .trig_hit(trig_hit), .overrun(overrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] e);
    wr_valid = 1'b1; wr_data = d; wr_err = e;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pop_chk(input string tag, input logic [7:0] d, input logic [2:0] e);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk(tag, {21'd0, rd_err, rd_data}, {21'd0, e, d});
  endtask

  task automatic pulse_clr();
    rx_clr = 1'b1;
    @(negedge clk);
    rx_clr = 1'b0;
  endtask

  task automatic pulse_stat();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ready", rx_ready, 0);
    chk("R1 trig", trig_hit, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 data", {rd_err, rd_data}, 0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) push(8'hA0 + 8'(i), 3'(i + 3));
    chk("R2 ready", rx_ready, 1);
    for (int i = 0; i < 5; i++) pop_chk("R2 order", 8'hA0 + 8'(i), 3'(i + 3));
    chk("R2 empty after", rx_ready, 0);
  endtask

  task automatic t_capacity();
    for (int i = 0; i < 64; i++) push(8'(i), 3'(i));
    chk("R4 no overrun at 64", overrun, 0);
    push(8'hEE, 3'h7);
    chk("R4 overrun on drop", overrun, 1);
    @(negedge clk);
    chk("R4 overrun held", overrun, 1);
    pulse_stat();
    chk("R4 overrun cleared", overrun, 0);
    wr_valid = 1'b1; wr_data = 8'h5A; wr_err = 3'h5; rd_req = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; rd_req = 1'b0;
    chk("R10 oldest returned", {rd_err, rd_data}, {3'h0, 8'h00});
    chk("R10 no overrun", overrun, 0);
    for (int i = 1; i < 64; i++) pop_chk("R3 contents", 8'(i), 3'(i));
    pop_chk("R10 tail kept", 8'h5A, 3'h5);
    chk("R3 empty after 64", rx_ready, 0);
  endtask

  task automatic t_trig();
    int th [4] = '{8, 16, 56, 60};
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      pulse_clr();
      for (int i = 0; i < th[s] - 1; i++) push(8'(i), 3'd1);
      chk($sformatf("R6 below th sel%0d", s), trig_hit, 0);
      push(8'h77, 3'd2);
      chk($sformatf("R6 at th sel%0d", s), trig_hit, 1);
      rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
      chk($sformatf("R6 after read sel%0d", s), trig_hit, 0);
    end
    pulse_clr();
    trig_sel = 2'b00;
  endtask

  task automatic t_clear();
    for (int i = 0; i < 9; i++) push(8'h10 + 8'(i), 3'd0);
    chk("R7 trig before clr", trig_hit, 1);
    rx_clr = 1'b1; wr_valid = 1'b1; wr_data = 8'hCC; wr_err = 3'h1;
    @(negedge clk);
    rx_clr = 1'b0; wr_valid = 1'b0;
    chk("R7 ready after clr", rx_ready, 0);
    chk("R7 trig after clr", trig_hit, 0);
    push(8'h3C, 3'h6);
    pop_chk("R7 fresh data", 8'h3C, 3'h6);
  endtask

  task automatic t_empty();
    rd_req = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd_req = 1'b0;
    chk("R8 empty read holds", {rd_err, rd_data}, {3'h6, 8'h3C});
    chk("R8 still empty", rx_ready, 0);
    push(8'h91, 3'h2);
    push(8'h92, 3'h3);
    pop_chk("R8 pointers intact a", 8'h91, 3'h2);
    pop_chk("R8 pointers intact b", 8'h92, 3'h3);
  endtask

  task automatic t_disabled();
    push(8'h01, 3'h0);
    push(8'h02, 3'h0);
    fifo_en = 1'b0;
    @(negedge clk);
    chk("R9 flush on disable", rx_ready, 0);
    push(8'hB1, 3'h1);
    chk("R5 one stored", rx_ready, 1);
    chk("R5 no overrun yet", overrun, 0);
    push(8'hB2, 3'h4);
    chk("R5 overwrite overrun", overrun, 1);
    pop_chk("R5 newest returned", 8'hB2, 3'h4);
    chk("R5 empty after read", rx_ready, 0);
    pulse_stat();
    push(8'hB3, 3'h2);
    chk("R5 no overrun after read", overrun, 0);
    fifo_en = 1'b1;
    @(negedge clk);
    chk("R9 flush on enable", rx_ready, 0);
    push(8'hC1, 3'h1);
    push(8'hC2, 3'h2);
    pop_chk("R9 fifo again a", 8'hC1, 3'h1);
    pop_chk("R9 fifo again b", 8'hC2, 3'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_order();
    t_capacity();
    t_trig();
    t_clear();
    t_empty();
    t_disabled();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1_000_000;
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule